// File: doc/BRIEF.md
# PWM Output Conditioning with Pair Swap and Dead Time

This block sits between a PWM timing unit and the pins for two complementary switch pairs, A and B. Each pair has a high-side and a low-side drive. For each pair the block can exchange the high-side and low-side timing signals. It then delays the turn-on edge of each drive by a programmable dead time, so that the two switches of a pair are never driven on together. Last, for each of the four pins it applies a polarity and an enable. The duty-cycle generation and the timing counter are outside the block; their results arrive as four plain inputs.

Configuration is written through a small write port into a shadow set. The shadow set is copied into the active set on a cycle-start strobe. When double-update mode is active, it is also copied on a mid-cycle strobe. Every pin is registered, so it follows its inputs with one clock of latency.

Register map (2-bit address, 8-bit data). Address 0 is control: bit 0 swaps pair A, bit 1 swaps pair B, bit 2 selects double-update mode. Address 1 holds the disable bits and address 2 the polarity bits. Both use bit 0 for AH, bit 1 for AL, bit 2 for BH and bit 3 for BL. Address 3 is the dead time in clock cycles.

Top module: `pwm_out_ctrl`

## Requirements
- R1: After reset, all pins are at 0. The active set has both swaps off, double update off, all outputs enabled, all polarities 1 (active-high) and dead time DT_RESET.
- R2: A write changes only the shadow set. Pins keep following the old active set until a cycle-start strobe. The new settings apply from the clock after the strobe edge.
- R3: A mid-cycle strobe loads the shadow set only while the active control bit 2 (double update) is 1. Otherwise it has no effect.
- R4: When a pair's swap bit is 1, the pair's high-side timing input drives its low-side pin and the low-side input drives its high-side pin. This holds only while both outputs of the pair are enabled and share the same polarity.
- R5: When a pair's swap bit is 1 but one of its outputs is disabled, or the two polarities differ, the pair passes its inputs straight through.
- R6: A drive turns active one clock after its post-swap signal has been high for dead time + 1 consecutive sampled cycles. It turns inactive one clock after that signal is sampled low. A pulse of dead time cycles or fewer never reaches the pin.
- R7: The two pins of a pair are never active in the same cycle. When both post-swap signals are high, both drives are inactive.
- R8: Polarity 1 makes a pin high when active. Polarity 0 inverts it, so the pin is low when active and high when inactive.
- R9: A disabled output sits at its inactive level (the inverse of its polarity bit), whatever its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 2 | Configuration register address |
| wr_data_i | input | 8 | Configuration write data |
| cyc_start_i | input | 1 | PWM cycle-start strobe |
| cyc_mid_i | input | 1 | PWM mid-cycle strobe |
| ah_i | input | 1 | Timing signal, pair A high side |
| al_i | input | 1 | Timing signal, pair A low side |
| bh_i | input | 1 | Timing signal, pair B high side |
| bl_i | input | 1 | Timing signal, pair B low side |
| ah_o | output | 1 | Pin, pair A high side |
| al_o | output | 1 | Pin, pair A low side |
| bh_o | output | 1 | Pin, pair B high side |
| bl_o | output | 1 | Pin, pair B low side |

## Verification
The main stimulus is a complementary pulse train with gaps. Pair B runs at a phase offset from pair A, so a routing mix-up between pairs shows. With gaps of two cycles against a dead time of four, turn-on delay is told apart from plain pass-through. The same train is replayed with the swap on, with mismatched polarities and with one output disabled; this separates a correct swap from a swap that ignores its qualifiers. Inputs that are high on both sides at once, and pulses shorter than the dead time, exercise the interlock and pulse suppression. Strobe sequences with and without double update show whether a load happened at the right strobe.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;
  localparam int DT_W  = 8;
  localparam int NPAIR = 2;
  localparam int NOUT  = 2 * NPAIR;
  localparam int AW    = 2;
  localparam int DW    = DT_W;

  localparam logic [AW-1:0] A_CTL = 2'd0;
  localparam logic [AW-1:0] A_DIS = 2'd1;
  localparam logic [AW-1:0] A_POL = 2'd2;
  localparam logic [AW-1:0] A_DT  = 2'd3;

  typedef struct packed {
    logic             dbl;
    logic [NPAIR-1:0] xov;
    logic [NOUT-1:0]  dis;
    logic [NOUT-1:0]  pol;
    logic [DT_W-1:0]  dt;
  } cfg_t;
endpackage

// File: rtl/pwm_oc_regs.sv
module pwm_oc_regs
  import pwm_oc_pkg::*;
#(
  parameter logic [DT_W-1:0] DT_RESET = 8'd4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cyc_start_i,
  input  logic          cyc_mid_i,
  output cfg_t          act_o
);
  localparam cfg_t RST_CFG = '{dbl: 1'b0, xov: '0, dis: '0, pol: '1, dt: DT_RESET};

  cfg_t shd_q, act_q;
  logic load;

  assign load  = cyc_start_i | (cyc_mid_i & act_q.dbl);
  assign act_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= RST_CFG;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTL: begin
          shd_q.xov <= wr_data_i[NPAIR-1:0];
          shd_q.dbl <= wr_data_i[NPAIR];
        end
        A_DIS:   shd_q.dis <= wr_data_i[NOUT-1:0];
        A_POL:   shd_q.pol <= wr_data_i[NOUT-1:0];
        default: shd_q.dt  <= wr_data_i[DT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_q <= RST_CFG;
    else if (load) act_q <= shd_q;
  end

  // R2
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_start_i && !cyc_mid_i) |=> $stable(act_q));

  // R3
  mid_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_mid_i && !cyc_start_i && !act_q.dbl) |=> $stable(act_q));
endmodule

// File: rtl/pwm_oc_pair.sv
module pwm_oc_pair
  import pwm_oc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hi_i,
  input  logic            lo_i,
  input  logic            xov_i,
  input  logic [1:0]      dis_i,   // [0] high side, [1] low side
  input  logic [1:0]      pol_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic       swap_en;
  logic [1:0] sw;
  logic [1:0] pin;

  // swap only valid with both sides enabled and equal polarity
  assign swap_en = xov_i & ~(|dis_i) & (pol_i[0] == pol_i[1]);
  assign sw[0]   = swap_en ? lo_i : hi_i;
  assign sw[1]   = swap_en ? hi_i : lo_i;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [DT_W-1:0] cnt_q;
    logic            act;
    logic            pin_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!sw[s])          cnt_q <= '0;
      else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
    end

    assign act = sw[s] & (cnt_q >= dt_i) & ~sw[1-s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_q <= 1'b0;
      else         pin_q <= (act & ~dis_i[s]) ^ ~pol_i[s];
    end

    assign pin[s] = pin_q;

    // R9
    dis_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dis_i[s] |=> (pin_q == ~$past(pol_i[s])));

    // R6
    dt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw[s] && !$past(sw[s]) && dt_i != '0) |=> (pin_q == ~$past(pol_i[s])));
  end

  assign hi_o = pin[0];
  assign lo_o = pin[1];

  // R7
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((pin[0] == $past(pol_i[0])) && (pin[1] == $past(pol_i[1]))));
endmodule

// File: rtl/pwm_out_ctrl.sv
module pwm_out_ctrl
  import pwm_oc_pkg::*;
#(
  parameter logic [DT_W-1:0] DT_RESET = 8'd4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cyc_start_i,
  input  logic          cyc_mid_i,
  input  logic          ah_i,
  input  logic          al_i,
  input  logic          bh_i,
  input  logic          bl_i,
  output logic          ah_o,
  output logic          al_o,
  output logic          bh_o,
  output logic          bl_o
);
  cfg_t             cfg;
  logic [NPAIR-1:0] tu_hi, tu_lo, pin_hi, pin_lo;

  assign tu_hi = {bh_i, ah_i};
  assign tu_lo = {bl_i, al_i};

  pwm_oc_regs #(.DT_RESET(DT_RESET)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .cyc_start_i (cyc_start_i),
    .cyc_mid_i   (cyc_mid_i),
    .act_o       (cfg)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_oc_pair u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hi_i   (tu_hi[p]),
      .lo_i   (tu_lo[p]),
      .xov_i  (cfg.xov[p]),
      .dis_i  (cfg.dis[2*p+1 -: 2]),
      .pol_i  (cfg.pol[2*p+1 -: 2]),
      .dt_i   (cfg.dt),
      .hi_o   (pin_hi[p]),
      .lo_o   (pin_lo[p])
    );
  end

  assign ah_o = pin_hi[0];
  assign al_o = pin_lo[0];
  assign bh_o = pin_hi[1];
  assign bl_o = pin_lo[1];
endmodule

// File: tb/pwm_out_ctrl_bench.sv
module pwm_out_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] ad = '0;
  logic [7:0] wd = '0;
  logic       st = 1'b0, mid = 1'b0;
  logic [3:0] tu = '0;   // [0]AH [1]AL [2]BH [3]BL
  logic [3:0] pins;

  always #2.5 clk = ~clk;

  pwm_out_ctrl u_pwm_out_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(ad), .wr_data_i(wd),
    .cyc_start_i(st), .cyc_mid_i(mid),
    .ah_i(tu[0]), .al_i(tu[1]), .bh_i(tu[2]), .bl_i(tu[3]),
    .ah_o(pins[0]), .al_o(pins[1]), .bh_o(pins[2]), .bl_o(pins[3])
  );

  typedef struct { logic [3:0] exp; logic [3:0] pol; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [2:0] sh_ctl = '0, ac_ctl = '0;
  logic [3:0] sh_dis = '0, ac_dis = '0, sh_pol = '1, ac_pol = '1;
  int sh_dt = 4, ac_dt = 4;
  int cnt [4] = '{0, 0, 0, 0};
  int t = 0;

  task automatic step(input logic [3:0] v, input logic s, input logic m,
                      input logic w, input logic [1:0] a, input logic [7:0] d,
                      input string tag);
    item_t it;
    logic [3:0] sw;
    @(negedge clk);
    tu = v; st = s; mid = m; we = w; ad = a; wd = d;
    for (int p = 0; p < 2; p++) begin
      logic hi, lo, swp;
      hi  = v[2*p]; lo = v[2*p+1];
      swp = ac_ctl[p] && !ac_dis[2*p] && !ac_dis[2*p+1] && (ac_pol[2*p] == ac_pol[2*p+1]);
      sw[2*p]   = swp ? lo : hi;
      sw[2*p+1] = swp ? hi : lo;
    end
    for (int k = 0; k < 4; k++) begin
      logic act;
      act = sw[k] && (cnt[k] >= ac_dt) && !sw[k^1];
      it.exp[k] = (act && !ac_dis[k]) ? ac_pol[k] : !ac_pol[k];
    end
    it.pol = ac_pol; it.tag = tag;
    q.push_back(it);
    for (int k = 0; k < 4; k++) cnt[k] = sw[k] ? ((cnt[k] < 255) ? cnt[k] + 1 : 255) : 0;
    if (s || (m && ac_ctl[2])) begin
      ac_ctl = sh_ctl; ac_dis = sh_dis; ac_pol = sh_pol; ac_dt = sh_dt;
    end
    if (w) case (a)
      2'd0: sh_ctl = d[2:0];
      2'd1: sh_dis = d[3:0];
      2'd2: sh_pol = d[3:0];
      default: sh_dt = int'(d);
    endcase
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(4'b0000, 0, 0, 1, a, d, tag);
  endtask

  task automatic strobe(input logic s, input logic m, input string tag);
    step(4'b0000, s, m, 0, 2'd0, 8'd0, tag);
  endtask

  // complementary trains with 2-cycle gaps, pair B phase-shifted
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [3:0] v;
      int pa, pb;
      pa = t % 20; pb = (t + 5) % 20;
      v[0] = pa < 8;  v[1] = (pa >= 10) && (pa < 18);
      v[2] = pb < 8;  v[3] = (pb >= 10) && (pb < 18);
      step(v, 0, 0, 0, 2'd0, 8'd0, tag);
      t++;
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (pins !== it.exp) begin
        n_fail++;
        $display("FAIL %s: pins=%b expected=%b", it.tag, pins, it.exp);
      end
      for (int p = 0; p < 2; p++) begin
        n_chk++;
        if (pins[2*p] == it.pol[2*p] && pins[2*p+1] == it.pol[2*p+1]) begin
          n_fail++;
          $display("FAIL R7 pair %0d both active: pins=%b expected no overlap (pol=%b)", p, pins, it.pol);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (pins !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 reset pins=%b expected=0000", pins);
    end
    @(negedge clk) rst_n = 1'b1;
    #1;
    n_chk++;
    if (pins !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 after release pins=%b expected=0000", pins);
    end

    run(40, "R1/R6 default dead time");
    wr(2'd3, 8'd2, "R2 write dt");
    run(40, "R2 shadow only");
    strobe(1, 0, "R2 start load");
    run(40, "R6 dt=2");

    wr(2'd0, 8'h01, "R3 write swap A");
    strobe(0, 1, "R3 mid w/o dbl");
    run(40, "R3 mid ignored");
    wr(2'd0, 8'h04, "R3 write dbl");
    strobe(1, 0, "R3 start load dbl");
    wr(2'd0, 8'h05, "R3 write swap A");
    strobe(0, 1, "R3 mid with dbl");
    run(40, "R4 swap A");

    step(4'b1111, 0, 0, 0, 2'd0, 8'd0, "R7 both high");
    repeat (6) step(4'b1111, 0, 0, 0, 2'd0, 8'd0, "R7 both high");
    run(20, "R7 recover");

    wr(2'd2, 8'h0D, "R5 pol AL=0");
    strobe(1, 0, "R5 load");
    run(40, "R5/R8 pol mismatch bypass");
    wr(2'd2, 8'h0F, "R9 pol restore");
    wr(2'd1, 8'h01, "R9 disable AH");
    strobe(1, 0, "R9 load");
    run(40, "R5/R9 disabled bypass");

    wr(2'd1, 8'h00, "R4 enable all");
    wr(2'd2, 8'h00, "R8 all active-low");
    wr(2'd0, 8'h06, "R4 swap B");
    strobe(1, 0, "R4 load");
    run(40, "R4/R8 swap B active-low");

    wr(2'd3, 8'd0, "R6 dt 0");
    wr(2'd2, 8'h0F, "R6 pol");
    strobe(1, 0, "R6 load");
    for (int i = 0; i < 6; i++) step(4'b0101, 0, 0, 0, 2'd0, 8'd0, "R6 dt0 pass");
    wr(2'd3, 8'd3, "R6 dt 3");
    strobe(1, 0, "R6 load 3");
    for (int i = 0; i < 4; i++) begin
      step(4'b0101, 0, 0, 0, 2'd0, 8'd0, "R6 short pulse suppressed");
      step(4'b0101, 0, 0, 0, 2'd0, 8'd0, "R6 short pulse suppressed");
      step(4'b0101, 0, 0, 0, 2'd0, 8'd0, "R6 short pulse suppressed");
      step(4'b0000, 0, 0, 0, 2'd0, 8'd0, "R6 short pulse suppressed");
    end
    run(40, "R6 dt=3 train");

    strobe(0, 0, "idle");
    @(posedge clk); #2;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule